// File: doc/BRIEF.md
# Serial Bit-Rate Timer with Majority Receive Voter

This block produces the timing for a serial port that runs in either asynchronous or synchronous framing. A down-counter reloads from a divisor value `n` and emits one prescale tick every `n+1` clocks. A second counter groups those ticks into one bit time: 64, 16 or 4 ticks, chosen by three mode inputs. The block drives a one-clock tick strobe, which marks each sub-bit sampling point, and a one-clock bit strobe.

The divisor is held as two bytes that are loaded through a simple write port. In narrow mode only the low byte is used. In wide mode the high and low bytes are joined. Any divisor write restarts the counters at once. So does any change in the effective mode. A new rate therefore takes effect without waiting for the old period to run out.

The receive line is sampled at three consecutive ticks around the middle of each bit. A 2-of-3 vote of those samples becomes the received level at the next bit strobe. An enable input stops all counting and keeps both strobes quiet.

Top module: `baud_timer`

## Requirements
- R1: After reset `tick_stb` and `bit_stb` are 0, `rx_vote` is 1 and both divisor bytes are 0. With all mode inputs low and the enable raised, the bit period is therefore 64 clocks.
- R2: When `wide_div`=0 the divisor `n` is the low byte alone, and any value written to the high byte has no effect on the period. When `wide_div`=1, `n` is {high byte, low byte}. A write with `wr_hi`=1 loads the high byte and a write with `wr_hi`=0 loads the low byte.
- R3: With `sync_mode`=0, `wide_div`=0 and `fast_div`=0, the bit period is 64·(n+1) clocks. For example, n=25 gives 1664 clocks.
- R4: With `sync_mode`=0 and exactly one of `wide_div` or `fast_div` set, the bit period is 16·(n+1) clocks.
- R5: With `sync_mode`=0, `wide_div`=1 and `fast_div`=1, the bit period is 4·(n+1) clocks.
- R6: With `sync_mode`=1 the bit period is 4·(n+1) clocks whatever the value of `fast_div`. Toggling `fast_div` in this mode neither restarts the counters nor shifts the phase of the bit strobe.
- R7: `tick_stb` pulses once every n+1 clocks. Each bit period holds exactly 64, 16 or 4 ticks, matching the mode, and `bit_stb` is high only in a cycle where `tick_stb` is also high.
- R8: A divisor write restarts the counters. The first `bit_stb` after the write comes on the P-th rising edge after the edge that captures the write, where P is the new bit period.
- R9: A change in the effective divide ratio or in `wide_div` restarts the counters. The first `bit_stb` then comes on the P-th rising edge after the edge that captures the change.
- R10: While `en`=0 both strobes stay low. After `en` rises, the first `bit_stb` comes on the P-th rising edge, counting the first edge that samples `en` high as edge 1.
- R11: With R ticks per bit, `rx_in` is sampled at ticks R/2−1, R/2 and R/2+1 after a bit strobe. On the next bit strobe `rx_vote` takes the 2-of-3 majority of those samples. `rx_vote` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| sync_mode | input | 1 | Synchronous framing select |
| wide_div | input | 1 | Use the full 16-bit divisor |
| fast_div | input | 1 | High-speed prescale select (asynchronous only) |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_hi | input | 1 | 1 selects the high byte, 0 the low byte |
| wr_data | input | 8 | Divisor byte value |
| rx_in | input | 1 | Receive line, synchronous to clk |
| tick_stb | output | 1 | One-clock prescale tick strobe |
| bit_stb | output | 1 | One-clock bit-time strobe |
| rx_vote | output | 1 | Majority-voted receive level |

## Verification
The period is measured for every row of the mode table, with divisors that fall in the low byte and divisors that need the high byte. These measurements separate the 64, 16 and 4 prescales and show whether the high byte is ignored or joined. The restart latency after writes, mode changes and enable is measured from known edges, which exposes any wait for the old period. A `fast_div` toggle in synchronous mode confirms that the strobe phase stays put. The voter is driven with one-sample glitches, two-sample runs and a line that is high only at the sampling points, which tells the sample positions and the 2-of-3 rule apart.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic [1:0] {
        RS_SLOW = 2'd0,
        RS_MID  = 2'd1,
        RS_FAST = 2'd2
    } rate_sel_e;
endpackage

// File: rtl/baud_divreg.sv
module baud_divreg #(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [DIV_W/2-1:0] wr_data,
    output logic [DIV_W-1:0]   div_next,
    output logic [DIV_W-1:0]   div_cur
);
    localparam int HALF_W = DIV_W / 2;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (wr_en) begin
            if (wr_hi) div_d.hi = wr_data;
            else       div_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign div_next = div_d;
    assign div_cur  = div_q;

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(div_q)); // R2
endmodule

// File: rtl/baud_counter.sv
module baud_counter import baud_pkg::*; #(
    parameter int DIV_W    = 16,
    parameter int SLOW_DIV = 64,
    parameter int MID_DIV  = 16,
    parameter int FAST_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync_mode,
    input  logic             wide_div,
    input  logic             fast_div,
    input  logic             wr_hit,
    input  logic [DIV_W-1:0] div_next,
    output logic             tick_o,
    output logic             bit_o,
    output logic             samp_now,
    output logic             bit_now
);
    localparam int HALF_W = DIV_W / 2;
    localparam int PW     = $clog2(SLOW_DIV);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [PW-1:0]    pcnt;
        logic             wide;
        rate_sel_e        rsel;
        logic             tick;
        logic             bstb;
    } cnt_t;

    localparam cnt_t RST_VAL = '{cnt: '0, pcnt: PW'(SLOW_DIV - 1), wide: 1'b0,
                                 rsel: RS_SLOW, tick: 1'b0, bstb: 1'b0};

    function automatic logic [PW-1:0] top_of(rate_sel_e s);
        case (s)
            RS_MID:  top_of = PW'(MID_DIV - 1);
            RS_FAST: top_of = PW'(FAST_DIV - 1);
            default: top_of = PW'(SLOW_DIV - 1);
        endcase
    endfunction

    cnt_t          d, q;
    rate_sel_e     rsel_in;
    logic [PW-1:0] ptop, mid;
    logic [DIV_W-1:0] n_sel;
    logic          restart, tick_c, bit_c, samp_c;

    always_comb begin
        if (sync_mode)                rsel_in = RS_FAST;
        else if (wide_div && fast_div) rsel_in = RS_FAST;
        else if (wide_div || fast_div) rsel_in = RS_MID;
        else                           rsel_in = RS_SLOW;

        ptop    = top_of(rsel_in);
        mid     = (ptop >> 1) + PW'(1);
        n_sel   = wide_div ? div_next : {{HALF_W{1'b0}}, div_next[HALF_W-1:0]};
        restart = wr_hit || !en || (wide_div != q.wide) || (rsel_in != q.rsel);
        tick_c  = !restart && (q.cnt == '0);
        bit_c   = tick_c && (q.pcnt == '0);
        samp_c  = tick_c && ((q.pcnt == mid + PW'(1)) || (q.pcnt == mid) ||
                             (q.pcnt == mid - PW'(1)));

        d      = q;
        d.wide = wide_div;
        d.rsel = rsel_in;
        d.tick = tick_c;
        d.bstb = bit_c;
        if (restart || tick_c) d.cnt = n_sel;
        else                   d.cnt = q.cnt - DIV_W'(1);
        if (restart)           d.pcnt = ptop;
        else if (tick_c)       d.pcnt = (q.pcnt == '0) ? ptop : q.pcnt - PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assign tick_o   = q.tick;
    assign bit_o    = q.bstb;
    assign samp_now = samp_c;
    assign bit_now  = bit_c;

    AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        q.bstb |-> q.tick); // R7
    AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.pcnt <= top_of(q.rsel)); // R7
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!q.tick && !q.bstb)); // R10
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (!q.tick && !q.bstb)); // R8
    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_div != q.wide) |=> !q.bstb); // R9
endmodule

// File: rtl/baud_vote.sv
module baud_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic samp_now,
    input  logic bit_now,
    output logic vote
);
    typedef struct packed {
        logic [2:0] smp;
        logic       vote;
    } vote_t;

    vote_t d, q;

    always_comb begin
        d = q;
        if (samp_now) d.smp = {q.smp[1:0], rx_in};
        if (bit_now)  d.vote = (q.smp[0] & q.smp[1]) | (q.smp[0] & q.smp[2]) |
                               (q.smp[1] & q.smp[2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{smp: 3'b111, vote: 1'b1};
        else        q <= d;
    end

    assign vote = q.vote;

    AST_VOTE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vote != $past(q.vote)) |-> $past(bit_now)); // R11
endmodule

// File: rtl/baud_timer.sv
module baud_timer #(
    parameter int DIV_W    = 16,
    parameter int SLOW_DIV = 64,
    parameter int MID_DIV  = 16,
    parameter int FAST_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               sync_mode,
    input  logic               wide_div,
    input  logic               fast_div,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [DIV_W/2-1:0] wr_data,
    input  logic               rx_in,
    output logic               tick_stb,
    output logic               bit_stb,
    output logic               rx_vote
);
    logic [DIV_W-1:0] div_next, div_cur;
    logic             samp_now, bit_now;

    baud_divreg #(.DIV_W(DIV_W)) u_divreg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_data(wr_data), .div_next(div_next), .div_cur(div_cur)
    );

    baud_counter #(
        .DIV_W(DIV_W), .SLOW_DIV(SLOW_DIV), .MID_DIV(MID_DIV), .FAST_DIV(FAST_DIV)
    ) u_counter (
        .clk(clk), .rst_n(rst_n), .en(en), .sync_mode(sync_mode),
        .wide_div(wide_div), .fast_div(fast_div), .wr_hit(wr_en),
        .div_next(div_next), .tick_o(tick_stb), .bit_o(bit_stb),
        .samp_now(samp_now), .bit_now(bit_now)
    );

    baud_vote u_vote (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .samp_now(samp_now),
        .bit_now(bit_now), .vote(rx_vote)
    );

    AST_RESET_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (div_cur == '0)); // R1
endmodule

// File: tb/baud_timer_bench.sv
module baud_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, sync_mode = 1'b0, wide_div = 1'b0, fast_div = 1'b0;
    logic       wr_en = 1'b0, wr_hi = 1'b0, rx_in = 1'b1;
    logic [7:0] wr_data = 8'h00;
    logic       tick_stb, bit_stb, rx_vote;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    baud_timer u_baud_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .sync_mode(sync_mode),
        .wide_div(wide_div), .fast_div(fast_div), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_data(wr_data), .rx_in(rx_in), .tick_stb(tick_stb),
        .bit_stb(bit_stb), .rx_vote(rx_vote)
    );

    // columns: sync, wide, fast, high byte, low byte, ticks per bit, bit period
    localparam int VEC [8][7] = '{
        '{0, 0, 0, 0, 25, 64, 1664},
        '{0, 0, 1, 0,  9, 16,  160},
        '{0, 1, 0, 1,  2, 16, 4144},
        '{0, 1, 1, 1,  0,  4, 1028},
        '{1, 0, 0, 0,  7,  4,   32},
        '{1, 0, 1, 0,  7,  4,   32},
        '{1, 1, 0, 2,  5,  4, 2072},
        '{0, 0, 0, 5,  3, 64,  256}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic hi, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic s, input logic w, input logic f);
        @(negedge clk);
        sync_mode = s; wide_div = w; fast_div = f;
        @(negedge clk);
    endtask

    task automatic wait_bit(output int cycles, output int ticks);
        cycles = 0; ticks = 0;
        do begin
            @(posedge clk); #1;
            cycles++;
            if (tick_stb) ticks++;
        end while (!bit_stb && cycles < 10000);
    endtask

    function automatic string mode_tag(input int s, input int w, input int f);
        if (s != 0)                return "R6";
        if (w != 0 && f != 0)      return "R5";
        if ((w != 0) != (f != 0))  return "R4";
        return "R3";
    endfunction

    function automatic logic pat(input int kind, input int j);
        logic at_s;
        at_s = (j == 28) || (j == 32) || (j == 36);
        case (kind)
            0: pat = (j != 32);
            1: pat = !((j == 28) || (j == 32));
            2: pat = at_s;
            default: pat = !((j == 32) || (j == 36));
        endcase
    endfunction

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        int c, t;
        repeat (3) @(posedge clk);
        #1;
        check("R1 tick after reset", int'(tick_stb), 0);
        check("R1 bit after reset", int'(bit_stb), 0);
        check("R1 vote after reset", int'(rx_vote), 1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); en = 1'b1;
        wait_bit(c, t);
        check("R1 R10 default period", c, 64);
        check("R1 R7 default ticks", t, 64);

        for (int i = 0; i < 8; i++) begin
            set_mode(VEC[i][0] != 0, VEC[i][1] != 0, VEC[i][2] != 0);
            wr(1'b1, 8'(VEC[i][3]));
            wr(1'b0, 8'(VEC[i][4]));
            wait_bit(c, t);
            check($sformatf("R8 latency vec%0d", i), c, VEC[i][6]);
            wait_bit(c, t);
            check($sformatf("%s %s period vec%0d", mode_tag(VEC[i][0], VEC[i][1], VEC[i][2]),
                            (i == 7) ? "R2" : "", i), c, VEC[i][6]);
            check($sformatf("R7 ticks vec%0d", i), t, VEC[i][5]);
        end

        // R8: write in the middle of a period restarts at once
        set_mode(1'b0, 1'b0, 1'b0);
        wr(1'b0, 8'd25);
        wait_bit(c, t);
        repeat (100) @(negedge clk);
        wr(1'b0, 8'd2);
        wait_bit(c, t);
        check("R8 mid-period write", c, 192);

        // R9: switching to wide mode restarts with the new ratio
        wr(1'b1, 8'd0);
        wr(1'b0, 8'd1);
        wait_bit(c, t);
        repeat (10) @(negedge clk);
        set_mode(1'b0, 1'b1, 1'b0);
        wait_bit(c, t);
        check("R9 mode change latency", c, 32);
        wait_bit(c, t);
        check("R9 R4 period after change", c, 32);

        // R6: fast_div toggle in sync mode keeps phase
        set_mode(1'b1, 1'b0, 1'b0);
        wr(1'b0, 8'd7);
        wait_bit(c, t);
        set_mode(1'b1, 1'b0, 1'b1);
        wait_bit(c, t);
        check("R6 fast toggle keeps phase", c, 31);
        wait_bit(c, t);
        check("R6 period after toggle", c, 32);

        // R10: enable low keeps strobes quiet, then restart on rise
        @(negedge clk); en = 1'b0;
        c = 0;
        for (int k = 0; k < 300; k++) begin
            @(posedge clk); #1;
            if (tick_stb || bit_stb) c++;
        end
        check("R10 strobes while disabled", c, 0);
        @(negedge clk); en = 1'b1;
        wait_bit(c, t);
        check("R10 first bit after enable", c, 32);
        check("R10 R7 ticks after enable", t, 4);

        // R11: majority voter, R=16 with n=3
        set_mode(1'b0, 1'b1, 1'b0);
        wr(1'b1, 8'd0);
        wr(1'b0, 8'd3);
        wait_bit(c, t);
        for (int kind = 0; kind < 4; kind++) begin
            for (int j = 1; j <= 64; j++) begin
                @(negedge clk); rx_in = pat(kind, j);
                @(posedge clk);
            end
            #1;
            check($sformatf("R11 bit strobe kind%0d", kind), int'(bit_stb), 1);
            check($sformatf("R11 vote kind%0d", kind), int'(rx_vote),
                  (kind == 0 || kind == 2) ? 1 : 0);
        end
        summary();
    end
endmodule